// File: doc/BRIEF.md
# Pin Function Select Multiplexer

This block sits between the general-purpose I/O logic, three alternate peripherals and the pad ring of a 35-pin port. Software programs, for each pin, which of four sources drives the pad: the GPIO path or one of three alternate functions. It also programs whether the pad's pull-up is enabled. Pins are grouped into banks of 32. A pin's bank is its number divided by 32, and its bit inside each bank register is the pin number modulo 32. Pins 32 to 34 therefore live in bank 1 at bits 0 to 2.

Each bank has four registers: three selection bitmaps and one pull-up bitmap. Each bitmap gives one bit to every pin of the bank, and the alternate functions do not share a packed code field. A pin is routed by a fixed priority across its three selection bits. Only some pins can carry the third alternate function. The block forwards the chosen source's output value and output enable to the pad and drives the pad's pull-up enable straight from the register bit.

Top module: `pin_func_mux`

## Requirements
- R1: After reset every selection and pull-up bit reads 0, every pad follows the GPIO source (`pad_out`=`gpio_out`, `pad_oe`=`gpio_oe`) and `pad_pu` is all zero.
- R2: Full-word writes with `bus_sel`=1 and `bus_we`=1 take effect on the next rising clock edge. Reads with `bus_sel`=1 and `bus_we`=0 return the register value on `bus_rdata` in the same cycle. The map is: first-alternate select 0x0C (bank 0) / 0x10 (bank 1), second-alternate select 0x14 / 0x18, third-alternate select 0x8C / 0x90, pull-up 0xAC / 0xB0.
- R3: A pin whose three selection bits are all clear passes `gpio_out` and `gpio_oe` to its pad, whatever pattern those inputs carry.
- R4: A pin with only its first-alternate, second-alternate or third-alternate selection bit set drives its pad from the `alt1_*`, `alt2_*` or `alt3_*` inputs respectively.
- R5: When several selection bits of a pin are set, the first-alternate bit wins over the second-alternate bit, and the second-alternate bit wins over the third-alternate bit.
- R6: The third alternate function exists only on pins 0–9, 20 and 22–34. On pins 10–19 and 21 a set third-alternate bit still reads back, but the pad stays on the GPIO source unless a higher-priority bit is set.
- R7: In every bank 1 register, bits 3 to 31 (pins 35 to 63, which do not exist) read as 0 and ignore writes.
- R8: A set pull-up bit drives the matching `pad_pu` bit high, and the bit reads back unchanged.
- R9: A read from an address outside the map returns 0, and a write to such an address changes no register and no pad.
- R10: Pin n is controlled by bit n mod 32 of the bank n/32 registers. For example, bank 1 bit 0 selects pin 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| gpio_out | input | 35 | GPIO output value per pin |
| gpio_oe | input | 35 | GPIO output enable per pin |
| alt1_out | input | 35 | First alternate function output value |
| alt1_oe | input | 35 | First alternate function output enable |
| alt2_out | input | 35 | Second alternate function output value |
| alt2_oe | input | 35 | Second alternate function output enable |
| alt3_out | input | 35 | Third alternate function output value |
| alt3_oe | input | 35 | Third alternate function output enable |
| pad_out | output | 35 | Output value sent to each pad |
| pad_oe | output | 35 | Output enable sent to each pad |
| pad_pu | output | 35 | Pull-up enable sent to each pad |

## Verification
The hardest case to reach is a pin whose third-alternate bit is set but which lacks that function, while its higher-priority bits are clear. A single all-ones write to the bank 0 third-alternate register reaches it: pins 10–19 and 21 must then stay on GPIO while their neighbours switch. Each alternate source is tied to a distinct constant pair of value and enable, so the bench can read the chosen function of every pin from the pads. The priority cases come from stacking the selection bits on one pin, one bit at a time. The bank 1 cases come from writes with all upper bits set.

// File: rtl/pfm_pkg.sv
package pfm_pkg;

   localparam int BANK_W = 32;

   typedef enum logic [1:0] {
      FN_GPIO = 2'd0,
      FN_ALT1 = 2'd1,
      FN_ALT2 = 2'd2,
      FN_ALT3 = 2'd3
   } pin_fn_e;

   typedef enum logic [1:0] {
      RK_PRI = 2'd0,
      RK_SEC = 2'd1,
      RK_TER = 2'd2,
      RK_PUP = 2'd3
   } reg_kind_e;

   // byte address of one control register of one bank
   function automatic logic [7:0] reg_addr(input int bank, input int kind);
      logic [7:0] a;
      case (kind)
         0:       a = (bank == 0) ? 8'h0C : 8'h10;
         1:       a = (bank == 0) ? 8'h14 : 8'h18;
         2:       a = (bank == 0) ? 8'h8C : 8'h90;
         default: a = (bank == 0) ? 8'hAC : 8'hB0;
      endcase
      return a;
   endfunction

endpackage

// File: rtl/pfm_regs.sv
module pfm_regs
   import pfm_pkg::*;
#(
   parameter int NUM_PINS = 35,
   parameter int NUM_BANKS = 2,
   parameter int FLAT_W = 64,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [FLAT_W-1:0] pri_q,
   output logic [FLAT_W-1:0] sec_q,
   output logic [FLAT_W-1:0] ter_q,
   output logic [FLAT_W-1:0] pup_q
);

   localparam int NREG = NUM_BANKS * 4;

   function automatic logic [BANK_W-1:0] valid_mask(input int b);
      logic [BANK_W-1:0] m;
      m = '0;
      for (int i = 0; i < BANK_W; i++)
         if (b * BANK_W + i < NUM_PINS) m[i] = 1'b1;
      return m;
   endfunction

   logic [BANK_W-1:0] reg_word [NREG];
   logic [BANK_W-1:0] rd_word  [NREG];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam logic [BANK_W-1:0] VMASK = valid_mask(b);
      for (genvar k = 0; k < 4; k++) begin : g_reg
         localparam logic [ADDR_W-1:0] ADDR = ADDR_W'(reg_addr(b, k));
         logic [BANK_W-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               r <= '0;
            else if (bus_sel && bus_we && bus_addr == ADDR)
               r <= bus_wdata[BANK_W-1:0] & VMASK;
         end
         assign reg_word[b*4+k] = r;
         assign rd_word[b*4+k]  = (bus_addr == ADDR) ? r : '0;
      end
      assign pri_q[b*BANK_W +: BANK_W] = reg_word[b*4+0];
      assign sec_q[b*BANK_W +: BANK_W] = reg_word[b*4+1];
      assign ter_q[b*BANK_W +: BANK_W] = reg_word[b*4+2];
      assign pup_q[b*BANK_W +: BANK_W] = reg_word[b*4+3];
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_we)
         for (int i = 0; i < NREG; i++)
            bus_rdata = bus_rdata | DATA_W'(rd_word[i]);
   end

   // R7
   if (NUM_BANKS == 2 && NUM_PINS < 2 * BANK_W) begin : g_hole_chk
      hole_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_sel && !bus_we && bus_addr == ADDR_W'(8'h10))
         |-> (bus_rdata[BANK_W-1:NUM_PINS-BANK_W] == '0));
   end

endmodule

// File: rtl/pfm_pin.sv
module pfm_pin
   import pfm_pkg::*;
#(
   parameter bit ALT3_OK = 1'b1
) (
   input  logic       sel_pri,
   input  logic       sel_sec,
   input  logic       sel_ter,
   input  logic [3:0] src_out,
   input  logic [3:0] src_oe,
   output logic       pad_out,
   output logic       pad_oe
);

   logic    ter_eff;
   pin_fn_e fn;

   if (ALT3_OK) begin : g_alt3
      assign ter_eff = sel_ter;
   end else begin : g_no_alt3
      assign ter_eff = 1'b0;
   end

   always_comb begin
      if (sel_pri)      fn = FN_ALT1;
      else if (sel_sec) fn = FN_ALT2;
      else if (ter_eff) fn = FN_ALT3;
      else              fn = FN_GPIO;
   end

   assign pad_out = src_out[fn];
   assign pad_oe  = src_oe[fn];

endmodule

// File: rtl/pin_func_mux.sv
module pin_func_mux
   import pfm_pkg::*;
#(
   parameter int          NUM_PINS  = 35,
   parameter int          ADDR_W    = 8,
   parameter int          DATA_W    = 32,
   parameter logic [63:0] ALT3_PINS = 64'h0000_0007_FFD0_03FF
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_sel,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [NUM_PINS-1:0] gpio_out,
   input  logic [NUM_PINS-1:0] gpio_oe,
   input  logic [NUM_PINS-1:0] alt1_out,
   input  logic [NUM_PINS-1:0] alt1_oe,
   input  logic [NUM_PINS-1:0] alt2_out,
   input  logic [NUM_PINS-1:0] alt2_oe,
   input  logic [NUM_PINS-1:0] alt3_out,
   input  logic [NUM_PINS-1:0] alt3_oe,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic [NUM_PINS-1:0] pad_pu
);

   localparam int NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W;
   localparam int FLAT_W    = NUM_BANKS * BANK_W;

   if (NUM_BANKS > 2) begin : g_bad_pins
      $error("pin_func_mux: address map covers two banks only");
   end
   if (DATA_W < BANK_W || ADDR_W < 8) begin : g_bad_bus
      $error("pin_func_mux: bus too narrow for the register map");
   end

   logic [FLAT_W-1:0] pri_q, sec_q, ter_q, pup_q;

   pfm_regs #(
      .NUM_PINS (NUM_PINS),
      .NUM_BANKS(NUM_BANKS),
      .FLAT_W   (FLAT_W),
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_sel  (bus_sel),
      .bus_we   (bus_we),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .pri_q    (pri_q),
      .sec_q    (sec_q),
      .ter_q    (ter_q),
      .pup_q    (pup_q)
   );

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      pfm_pin #(.ALT3_OK(ALT3_PINS[p])) u_pin (
         .sel_pri(pri_q[p]),
         .sel_sec(sec_q[p]),
         .sel_ter(ter_q[p]),
         .src_out({alt3_out[p], alt2_out[p], alt1_out[p], gpio_out[p]}),
         .src_oe ({alt3_oe[p],  alt2_oe[p],  alt1_oe[p],  gpio_oe[p]}),
         .pad_out(pad_out[p]),
         .pad_oe (pad_oe[p])
      );

      if (!ALT3_PINS[p]) begin : g_no3_chk
         // R6
         alt3_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!pri_q[p] && !sec_q[p])
            |-> (pad_out[p] == gpio_out[p] && pad_oe[p] == gpio_oe[p]));
      end
   end

   assign pad_pu = pup_q[NUM_PINS-1:0];

   // R1
   reset_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pad_pu == '0 && pad_out == gpio_out && pad_oe == gpio_oe));

   // R3
   gpio_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pri_q | sec_q | ter_q) == '0) |-> (pad_out == gpio_out && pad_oe == gpio_oe));

   if (NUM_PINS >= BANK_W) begin : g_pu_chk
      // R8
      pullup_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_sel && bus_we && bus_addr == ADDR_W'(8'hAC))
         |=> (pad_pu[BANK_W-1:0] == $past(bus_wdata[BANK_W-1:0])));
   end

endmodule

// File: tb/pin_func_mux_bench.sv
module pin_func_mux_bench;

   localparam int          NP    = 35;
   localparam logic [63:0] ALT3  = 64'h0000_0007_FFD0_03FF;
   localparam int          NVEC  = 10;
   // {address, write data, expected read-back}
   localparam logic [71:0] VEC [NVEC] = '{
      {8'h0C, 32'h1234_5678, 32'h1234_5678},
      {8'h14, 32'hA5A5_A5A5, 32'hA5A5_A5A5},
      {8'h8C, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
      {8'hAC, 32'h0F0F_0F0F, 32'h0F0F_0F0F},
      {8'h10, 32'hFFFF_FFFF, 32'h0000_0007},
      {8'h18, 32'hFFFF_FFF2, 32'h0000_0002},
      {8'h90, 32'h0000_0008, 32'h0000_0000},
      {8'hB0, 32'h0000_0005, 32'h0000_0005},
      {8'h40, 32'hFFFF_FFFF, 32'h0000_0000},
      {8'h0C, 32'h0000_0000, 32'h0000_0000}
   };
   localparam string VTAG [NVEC] = '{"R2", "R2", "R2", "R8", "R7", "R7", "R7", "R7", "R9", "R2"};

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0, bus_we = 1'b0;
   logic [7:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] gpio_out = '0, gpio_oe = '0;
   logic [NP-1:0] alt1_out = '1, alt1_oe = '0;
   logic [NP-1:0] alt2_out = '0, alt2_oe = '1;
   logic [NP-1:0] alt3_out = '1, alt3_oe = '1;
   logic [NP-1:0] pad_out, pad_oe, pad_pu;

   pin_func_mux u_pin_func_mux (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .gpio_out(gpio_out), .gpio_oe(gpio_oe),
      .alt1_out(alt1_out), .alt1_oe(alt1_oe),
      .alt2_out(alt2_out), .alt2_oe(alt2_oe),
      .alt3_out(alt3_out), .alt3_oe(alt3_oe),
      .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
   );

   int n_chk = 0, n_fail = 0;
   logic [63:0] m_pri = '0, m_sec = '0, m_ter = '0, m_pup = '0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      m_pri = '0; m_sec = '0; m_ter = '0; m_pup = '0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      case (a)
         8'h0C: m_pri[31:0]  = d;
         8'h10: m_pri[63:32] = d & 32'h7;
         8'h14: m_sec[31:0]  = d;
         8'h18: m_sec[63:32] = d & 32'h7;
         8'h8C: m_ter[31:0]  = d;
         8'h90: m_ter[63:32] = d & 32'h7;
         8'hAC: m_pup[31:0]  = d;
         8'hB0: m_pup[63:32] = d & 32'h7;
         default: ;
      endcase
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1;
      chk(tag, 64'(bus_rdata), 64'(exp));
      bus_sel = 1'b0;
   endtask

   // expected pads from the requirement priority rules
   task automatic chk_pads(input string tag);
      logic [NP-1:0] eo, ee;
      #1;
      for (int p = 0; p < NP; p++) begin
         if (m_pri[p])                 begin eo[p] = alt1_out[p]; ee[p] = alt1_oe[p]; end
         else if (m_sec[p])            begin eo[p] = alt2_out[p]; ee[p] = alt2_oe[p]; end
         else if (m_ter[p] && ALT3[p]) begin eo[p] = alt3_out[p]; ee[p] = alt3_oe[p]; end
         else                          begin eo[p] = gpio_out[p]; ee[p] = gpio_oe[p]; end
      end
      chk({tag, " pad_out"}, 64'(pad_out), 64'(eo));
      chk({tag, " pad_oe"},  64'(pad_oe),  64'(ee));
      chk({tag, " pad_pu"},  64'(pad_pu),  m_pup & 64'h7_FFFF_FFFF);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(200000 * 4);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      do_reset();
      // R1 reset state
      foreach (VEC[i]) if (VEC[i][71:64] != 8'h40) rd_chk(VEC[i][71:64], 32'h0, "R1 reset readback");
      chk_pads("R1 reset pads");

      // table walk: R2 map, R7 hole bits, R9 unmapped, R8 readback
      for (int i = 0; i < NVEC; i++) begin
         wr(VEC[i][71:64], VEC[i][63:32]);
         rd_chk(VEC[i][71:64], VEC[i][31:0], {VTAG[i], " table readback"});
         chk_pads({VTAG[i], " table pads"});
      end
      // R9 unmapped write left registers intact
      rd_chk(8'h14, 32'hA5A5_A5A5, "R9 after unmapped write");
      rd_chk(8'hB0, 32'h5, "R9 after unmapped write");

      // R3 gpio pass-through under two patterns
      do_reset();
      gpio_out = 35'h5_A5A5_A5A5; gpio_oe = 35'h2_3C3C_0FF0;
      chk_pads("R3 gpio pattern A");
      gpio_out = ~gpio_out; gpio_oe = 35'h7_0000_FFFF;
      chk_pads("R3 gpio pattern B");
      gpio_out = '0; gpio_oe = '0;

      // R4 single selections, R10 bank 1 pins
      wr(8'h0C, 32'h20); wr(8'h14, 32'h40); wr(8'h8C, 32'h80);
      chk_pads("R4 single select bank0");
      chk(64'(pad_out[7:5]) == 64'h5 ? "R4 pins5-7 out" : "R4 pins5-7 out", 64'(pad_out[7:5]), 64'b101);
      wr(8'h10, 32'h1); wr(8'h90, 32'h4);
      chk_pads("R10 bank1 pins");
      chk("R10 pin32 alt1", 64'({pad_out[32], pad_oe[32]}), 64'b10);
      chk("R10 pin34 alt3", 64'({pad_out[34], pad_oe[34]}), 64'b11);

      // R5 priority
      do_reset();
      wr(8'h0C, 32'h8); wr(8'h14, 32'h18); wr(8'h8C, 32'h18);
      chk("R5 pin3 first wins", 64'({pad_out[3], pad_oe[3]}), 64'b10);
      chk("R5 pin4 second wins", 64'({pad_out[4], pad_oe[4]}), 64'b01);
      chk_pads("R5 priority pads");

      // R6 third function on pins lacking it
      do_reset();
      gpio_out = 35'h0_0000_0000; gpio_oe = '0;
      wr(8'h8C, 32'hFFFF_FFFF);
      rd_chk(8'h8C, 32'hFFFF_FFFF, "R6 readback");
      chk("R6 pins10-19 stay gpio", 64'(pad_oe[19:10]), 64'h0);
      chk("R6 pin21 stays gpio", 64'(pad_oe[21]), 64'h0);
      chk("R6 pin20 alt3", 64'(pad_oe[20]), 64'h1);
      chk_pads("R6 pads");

      // R8 pull-up drive
      wr(8'hAC, 32'h8000_0001); wr(8'hB0, 32'h6);
      chk("R8 pad_pu", 64'(pad_pu), 64'h6_8000_0001);

      // R1 reset from a busy state
      do_reset();
      rd_chk(8'h8C, 32'h0, "R1 second reset");
      chk_pads("R1 second reset pads");

      finish_run();
   end

endmodule